// File: doc/BRIEF.md
# 32-to-64-bit Register Access Bridge

The bridge gives a 32-bit host register port access to the 64-bit registers of a downstream controller through a five-register window. The host fills two 32-bit data registers and then writes a command word. The command word carries a direction bit and a downstream register address, and that write starts exactly one 64-bit downstream access. The high data register always holds the upper half of the 64-bit word and the low data register holds the lower half. This applies both when write data is assembled and when read data is returned.

The bridge handles one downstream access at a time. While that access is outstanding, a busy bit in the status word is set. Several conditions raise a sticky error bit in the status word: a command issued while busy, a command naming a register the downstream controller does not have, and an error response from downstream. A write of any value to the clear register drops the error bit.

Both sides use a simple valid/ready register port. The host side is always ready and answers every read one cycle after the read is accepted. The downstream side holds a request until it is accepted and then waits for a single response.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, the status word, both data registers and the command register read as zero, and no downstream request is raised.
- R2: A host write to the command register (offset 0x08) with bit 31 set and a valid address issues one downstream write. Its address is the command word's low bits and its data is {high data register (0x00), low data register (0x04)}. The request fields stay stable until the downstream side accepts them.
- R3: A command with bit 31 clear issues one downstream read. On a good response, the high data register takes response bits 63:32 and the low data register takes bits 31:0.
- R4: Status bit 0 (busy) is set from the cycle after a command is accepted until the cycle after its downstream response. A rise of busy always comes with a downstream request.
- R5: A command written while busy raises no downstream request and leaves the command register unchanged. It sets status bit 31.
- R6: A command whose address field (bits 30:0) is NUM_REGS or more raises no downstream request and leaves busy clear. It sets status bit 31.
- R7: A downstream error response sets status bit 31. For a read, it leaves both data registers unchanged.
- R8: A host write of any value to the clear register (offset 0x18) clears status bit 31. If an error event lands in the same cycle, the bit stays set.
- R9: Both data registers can be read at any time and take host writes at any time. A read completion in the same cycle as a host data write takes precedence.
- R10: Write data is captured when the command is accepted, so host data writes made while that write is pending do not change the downstream write data.
- R11: Every accepted host read is answered with a response one cycle later, and no response appears otherwise. Offsets other than 0x00, 0x04, 0x08, 0x18 and 0x1C read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request ready (always high) |
| h_write | input | 1 | Host request is a write |
| h_addr | input | HOST_AW | Host byte offset in the window |
| h_wdata | input | 32 | Host write data |
| h_rvalid | output | 1 | Host read response valid |
| h_rdata | output | 32 | Host read response data |
| d_req_valid | output | 1 | Downstream request valid |
| d_req_ready | input | 1 | Downstream request accepted |
| d_req_write | output | 1 | Downstream request is a write |
| d_req_addr | output | ADDR_W | Downstream register index |
| d_req_wdata | output | 64 | Downstream write data |
| d_rsp_valid | input | 1 | Downstream response valid |
| d_rsp_rdata | input | 64 | Downstream read data |
| d_rsp_err | input | 1 | Downstream error response |

## Verification
Two events can land on the same clock edge: a host write to the clear register and a downstream error response, which raises the error bit. The bench holds back the downstream responder and then releases the error response on the exact negative edge at which it drives the clear write. A later status read must still show bit 31 set. The opposite case is also exercised: a good read completion is released together with a clear write, and also together with a host write to a data register. Afterwards the error bit must be clear, and the data registers must hold the response, not the host value.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

    localparam int HOST_DW = 32;
    localparam int WIDE_DW = 64;

    // Window byte offsets
    localparam logic [7:0] OFS_DATA_HI = 8'h00;
    localparam logic [7:0] OFS_DATA_LO = 8'h04;
    localparam logic [7:0] OFS_CMD     = 8'h08;
    localparam logic [7:0] OFS_CLR     = 8'h18;
    localparam logic [7:0] OFS_STATUS  = 8'h1C;

    localparam int STS_ERR_BIT  = 31;
    localparam int STS_BUSY_BIT = 0;

    typedef struct packed {
        logic        wr;
        logic [30:0] addr;
    } cmd_word_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic data_hi;
        logic data_lo;
        logic cmd;
        logic clr;
    } host_wstb_t;

    typedef enum logic [2:0] {
        RS_DATA_HI,
        RS_DATA_LO,
        RS_CMD,
        RS_STATUS,
        RS_NONE
    } rsel_t;

    function automatic logic [HOST_DW-1:0] status_word(input logic err, input logic busy);
        logic [HOST_DW-1:0] w;
        w = '0;
        w[STS_ERR_BIT]  = err;
        w[STS_BUSY_BIT] = busy;
        return w;
    endfunction

    function automatic logic [WIDE_DW-1:0] join_halves(input logic [HOST_DW-1:0] hi,
                                                       input logic [HOST_DW-1:0] lo);
        return {hi, lo};
    endfunction

    function automatic logic addr_in_range(input logic [30:0] a, input int unsigned n);
        return ({1'b0, a} < n);
    endfunction

endpackage

// File: rtl/wrb_host_port.sv
module wrb_host_port
    import wrb_pkg::*;
#(
    parameter int HOST_AW = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_valid,
    input  logic               h_write,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic [HOST_DW-1:0] data_hi,
    input  logic [HOST_DW-1:0] data_lo,
    input  logic [HOST_DW-1:0] cmd_val,
    input  logic [HOST_DW-1:0] status_val,
    output host_wstb_t         wstb,
    output logic               h_rvalid,
    output logic [HOST_DW-1:0] h_rdata
);

    logic [7:0] ofs;
    rsel_t      rsel;
    logic       wr_go;
    logic       rd_go;
    logic [HOST_DW-1:0] rd_mux;

    assign ofs   = 8'(h_addr);
    assign wr_go = h_valid && h_write;
    assign rd_go = h_valid && !h_write;

    always_comb begin
        case (ofs)
            OFS_DATA_HI: rsel = RS_DATA_HI;
            OFS_DATA_LO: rsel = RS_DATA_LO;
            OFS_CMD:     rsel = RS_CMD;
            OFS_STATUS:  rsel = RS_STATUS;
            default:     rsel = RS_NONE;
        endcase
    end

    always_comb begin
        wstb.data_hi = wr_go && (ofs == OFS_DATA_HI);
        wstb.data_lo = wr_go && (ofs == OFS_DATA_LO);
        wstb.cmd     = wr_go && (ofs == OFS_CMD);
        wstb.clr     = wr_go && (ofs == OFS_CLR);
    end

    always_comb begin
        case (rsel)
            RS_DATA_HI: rd_mux = data_hi;
            RS_DATA_LO: rd_mux = data_lo;
            RS_CMD:     rd_mux = cmd_val;
            RS_STATUS:  rd_mux = status_val;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_rvalid <= 1'b0;
            h_rdata  <= '0;
        end else begin
            h_rvalid <= rd_go;
            if (rd_go) begin
                h_rdata <= rd_mux;
            end
        end
    end

endmodule

// File: rtl/wrb_sequencer.sv
module wrb_sequencer
    import wrb_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               start_wr,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [WIDE_DW-1:0] start_wdata,
    input  logic               d_req_ready,
    input  logic               d_rsp_valid,
    input  logic [WIDE_DW-1:0] d_rsp_rdata,
    input  logic               d_rsp_err,
    output logic               busy,
    output logic               d_req_valid,
    output logic               d_req_write,
    output logic [ADDR_W-1:0]  d_req_addr,
    output logic [WIDE_DW-1:0] d_req_wdata,
    output logic               rd_done,
    output logic [WIDE_DW-1:0] rd_data,
    output logic               rsp_fail
);

    seq_state_t         st;
    logic               wr_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [WIDE_DW-1:0] wdata_q;
    logic               rsp_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        st      <= SQ_ISSUE;
                        wr_q    <= start_wr;
                        addr_q  <= start_addr;
                        wdata_q <= start_wr ? start_wdata : '0;
                    end
                end
                SQ_ISSUE: begin
                    if (d_req_ready) begin
                        st <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (d_rsp_valid) begin
                        st <= SQ_IDLE;
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assign busy        = (st != SQ_IDLE);
    assign d_req_valid = (st == SQ_ISSUE);
    assign d_req_write = wr_q;
    assign d_req_addr  = addr_q;
    assign d_req_wdata = wdata_q;

    assign rsp_fire = (st == SQ_WAIT) && d_rsp_valid;
    assign rd_done  = rsp_fire && !wr_q && !d_rsp_err;
    assign rd_data  = d_rsp_rdata;
    assign rsp_fail = rsp_fire && d_rsp_err;

endmodule

// File: rtl/wrb_err_flag.sv
module wrb_err_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // A raising event outranks a clear landing on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import wrb_pkg::*;
#(
    parameter int          HOST_AW  = 5,
    parameter int unsigned NUM_REGS = 16,
    localparam int         ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_valid,
    output logic               h_ready,
    input  logic               h_write,
    input  logic [HOST_AW-1:0] h_addr,
    input  logic [31:0]        h_wdata,
    output logic               h_rvalid,
    output logic [31:0]        h_rdata,
    output logic               d_req_valid,
    input  logic               d_req_ready,
    output logic               d_req_write,
    output logic [ADDR_W-1:0]  d_req_addr,
    output logic [63:0]        d_req_wdata,
    input  logic               d_rsp_valid,
    input  logic [63:0]        d_rsp_rdata,
    input  logic               d_rsp_err
);

    host_wstb_t         wstb;
    cmd_word_t          cmd_in;
    logic [HOST_DW-1:0] data_hi_q;
    logic [HOST_DW-1:0] data_lo_q;
    logic [HOST_DW-1:0] cmd_q;
    logic               busy;
    logic               err_flag;
    logic               addr_ok;
    logic               start;
    logic               err_set;
    logic               rd_done;
    logic [WIDE_DW-1:0] rd_data;
    logic               rsp_fail;

    assign h_ready = 1'b1;
    assign cmd_in  = cmd_word_t'(h_wdata);
    assign addr_ok = addr_in_range(cmd_in.addr, NUM_REGS);
    assign start   = wstb.cmd && !busy && addr_ok;
    assign err_set = (wstb.cmd && (busy || !addr_ok)) || rsp_fail;

    wrb_host_port #(.HOST_AW(HOST_AW)) u_host (
        .clk        (clk),
        .rst        (rst),
        .h_valid    (h_valid),
        .h_write    (h_write),
        .h_addr     (h_addr),
        .data_hi    (data_hi_q),
        .data_lo    (data_lo_q),
        .cmd_val    (cmd_q),
        .status_val (status_word(err_flag, busy)),
        .wstb       (wstb),
        .h_rvalid   (h_rvalid),
        .h_rdata    (h_rdata)
    );

    wrb_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .start_wr    (cmd_in.wr),
        .start_addr  (cmd_in.addr[ADDR_W-1:0]),
        .start_wdata (join_halves(data_hi_q, data_lo_q)),
        .d_req_ready (d_req_ready),
        .d_rsp_valid (d_rsp_valid),
        .d_rsp_rdata (d_rsp_rdata),
        .d_rsp_err   (d_rsp_err),
        .busy        (busy),
        .d_req_valid (d_req_valid),
        .d_req_write (d_req_write),
        .d_req_addr  (d_req_addr),
        .d_req_wdata (d_req_wdata),
        .rd_done     (rd_done),
        .rd_data     (rd_data),
        .rsp_fail    (rsp_fail)
    );

    wrb_err_flag u_err (
        .clk  (clk),
        .rst  (rst),
        .set  (err_set),
        .clr  (wstb.clr),
        .flag (err_flag)
    );

    // Data halves: a completing read outranks a host write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            data_hi_q <= '0;
            data_lo_q <= '0;
            cmd_q     <= '0;
        end else begin
            if (rd_done) begin
                data_hi_q <= rd_data[WIDE_DW-1:HOST_DW];
                data_lo_q <= rd_data[HOST_DW-1:0];
            end else begin
                if (wstb.data_hi) data_hi_q <= h_wdata;
                if (wstb.data_lo) data_lo_q <= h_wdata;
            end
            if (start) begin
                cmd_q <= h_wdata;
            end
        end
    end

endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk
    import wrb_pkg::*;
#(
    parameter int          HOST_AW  = 5,
    parameter int          ADDR_W   = 4,
    parameter int unsigned NUM_REGS = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               h_valid,
    input logic               h_write,
    input logic [HOST_AW-1:0] h_addr,
    input logic [31:0]        h_wdata,
    input logic               h_rvalid,
    input logic               d_req_valid,
    input logic               d_req_ready,
    input logic               d_req_write,
    input logic [ADDR_W-1:0]  d_req_addr,
    input logic [63:0]        d_req_wdata,
    input logic               d_rsp_valid,
    input logic               d_rsp_err,
    input logic               busy,
    input logic               err_flag
);

    localparam logic [31:0] LIMIT = 32'(NUM_REGS);

    logic cmd_wr;
    logic clr_wr;
    logic host_rd;

    assign cmd_wr  = h_valid && h_write && (8'(h_addr) == OFS_CMD);
    assign clr_wr  = h_valid && h_write && (8'(h_addr) == OFS_CLR);
    assign host_rd = h_valid && !h_write;

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        d_req_valid && !d_req_ready |=> d_req_valid && $stable(d_req_addr)
            && $stable(d_req_write) && $stable(d_req_wdata));

    // R4
    busy_req_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> d_req_valid);

    // R5
    busy_cmd_err_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && busy |=> err_flag);

    // R5
    busy_cmd_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && busy && !d_req_valid |=> !d_req_valid);

    // R6
    bad_addr_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr && !busy && ({1'b0, h_wdata[30:0]} >= LIMIT) |=> !busy && !d_req_valid && err_flag);

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr && !(d_rsp_valid && d_rsp_err) |=> !err_flag);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        d_rsp_valid && d_rsp_err && busy && !d_req_valid |=> err_flag);

    // R11
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        host_rd |=> h_rvalid);

    // R11
    rsp_only_chk: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> !h_rvalid);

endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(
    .HOST_AW  (HOST_AW),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .h_valid     (h_valid),
    .h_write     (h_write),
    .h_addr      (h_addr),
    .h_wdata     (h_wdata),
    .h_rvalid    (h_rvalid),
    .d_req_valid (d_req_valid),
    .d_req_ready (d_req_ready),
    .d_req_write (d_req_write),
    .d_req_addr  (d_req_addr),
    .d_req_wdata (d_req_wdata),
    .d_rsp_valid (d_rsp_valid),
    .d_rsp_err   (d_rsp_err),
    .busy        (busy),
    .err_flag    (err_flag)
);

// File: tb/wide_reg_bridge_bench.sv
`timescale 1ns/1ps
module wide_reg_bridge_bench;

    localparam int HOST_AW  = 5;
    localparam int NUM_REGS = 16;
    localparam int ADDR_W   = $clog2(NUM_REGS);

    localparam logic [7:0] A_HI  = 8'h00;
    localparam logic [7:0] A_LO  = 8'h04;
    localparam logic [7:0] A_CMD = 8'h08;
    localparam logic [7:0] A_CLR = 8'h18;
    localparam logic [7:0] A_STS = 8'h1C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic               h_valid = 1'b0;
    logic               h_ready;
    logic               h_write = 1'b0;
    logic [HOST_AW-1:0] h_addr = '0;
    logic [31:0]        h_wdata = '0;
    logic               h_rvalid;
    logic [31:0]        h_rdata;
    logic               d_req_valid;
    logic               d_req_ready;
    logic               d_req_write;
    logic [ADDR_W-1:0]  d_req_addr;
    logic [63:0]        d_req_wdata;
    logic               d_rsp_valid;
    logic [63:0]        d_rsp_rdata;
    logic               d_rsp_err;

    // Downstream responder model
    logic [63:0]       mem [NUM_REGS];
    int                mst = 0;
    int                cnt = 0;
    int                acc_dly = 0;
    int                rsp_dly = 0;
    int                rsp_mode = 0;
    bit                err_inject = 1'b0;
    int                ds_req_count = 0;
    logic              cap_wr = 1'b0;
    logic [ADDR_W-1:0] cap_addr = '0;
    logic [63:0]       cap_wdata = '0;
    logic              mdl_ready = 1'b0;
    logic              mdl_rsp_v = 1'b0;
    logic              mdl_rsp_e = 1'b0;
    logic [63:0]       mdl_rsp_d = '0;
    logic              man_rsp_v = 1'b0;
    logic              man_rsp_e = 1'b0;
    logic [63:0]       man_rsp_d = '0;

    assign d_req_ready = mdl_ready;
    assign d_rsp_valid = mdl_rsp_v | man_rsp_v;
    assign d_rsp_err   = (mdl_rsp_v & mdl_rsp_e) | (man_rsp_v & man_rsp_e);
    assign d_rsp_rdata = man_rsp_v ? man_rsp_d : mdl_rsp_d;

    always @(negedge clk) begin
        mdl_ready = 1'b0;
        mdl_rsp_v = 1'b0;
        mdl_rsp_e = 1'b0;
        if (rst) begin
            mst = 0;
            cnt = 0;
            for (int i = 0; i < NUM_REGS; i++) mem[i] = '0;
        end else begin
            case (mst)
                0: if (d_req_valid) begin
                    if (cnt >= acc_dly) begin
                        mdl_ready = 1'b1;
                        cap_wr    = d_req_write;
                        cap_addr  = d_req_addr;
                        cap_wdata = d_req_wdata;
                        mst = 1;
                        cnt = 0;
                    end else begin
                        cnt++;
                    end
                end
                1: begin
                    ds_req_count++;
                    if (cap_wr && !err_inject) mem[cap_addr] = cap_wdata;
                    mst = 2;
                    cnt = 0;
                end
                2: begin
                    if (rsp_mode == 2) begin
                        mst = 0;
                    end else if (rsp_mode == 0) begin
                        if (cnt >= rsp_dly) begin
                            mdl_rsp_v = 1'b1;
                            mdl_rsp_e = err_inject;
                            mdl_rsp_d = err_inject ? 64'hBAD0_BAD0_BAD0_BAD0 : mem[cap_addr];
                            mst = 0;
                            cnt = 0;
                        end else begin
                            cnt++;
                        end
                    end
                end
                default: mst = 0;
            endcase
        end
    end

    wide_reg_bridge #(.HOST_AW(HOST_AW), .NUM_REGS(NUM_REGS)) u_wide_reg_bridge (
        .clk(clk), .rst(rst),
        .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write), .h_addr(h_addr),
        .h_wdata(h_wdata), .h_rvalid(h_rvalid), .h_rdata(h_rdata),
        .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_write(d_req_write),
        .d_req_addr(d_req_addr), .d_req_wdata(d_req_wdata),
        .d_rsp_valid(d_rsp_valid), .d_rsp_rdata(d_rsp_rdata), .d_rsp_err(d_rsp_err)
    );

    int   checks = 0;
    int   errors = 0;
    logic last_rv;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] ofs, input logic [31:0] v);
        @(negedge clk);
        h_valid = 1'b1; h_write = 1'b1; h_addr = HOST_AW'(ofs); h_wdata = v;
        @(negedge clk);
        h_valid = 1'b0; h_write = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] ofs, output logic [31:0] v);
        @(negedge clk);
        h_valid = 1'b1; h_write = 1'b0; h_addr = HOST_AW'(ofs);
        @(negedge clk);
        h_valid = 1'b0;
        v = h_rdata;
        last_rv = h_rvalid;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 200; i++) begin
            host_rd(A_STS, s);
            if (!s[0]) break;
        end
    endtask

    task automatic coincide(input logic [7:0] ofs, input logic [31:0] v,
                            input logic e, input logic [63:0] d);
        @(negedge clk);
        h_valid = 1'b1; h_write = 1'b1; h_addr = HOST_AW'(ofs); h_wdata = v;
        man_rsp_v = 1'b1; man_rsp_e = e; man_rsp_d = d;
        @(negedge clk);
        h_valid = 1'b0; h_write = 1'b0; man_rsp_v = 1'b0; man_rsp_e = 1'b0;
        @(posedge clk); #1 rsp_mode = 2;
        repeat (2) @(posedge clk);
        #1 rsp_mode = 0;
    endtask

    function automatic logic [63:0] pat(input int a);
        logic [31:0] h;
        h = 32'h9E37_79B9 * 32'(a + 1);
        return {h, ~h ^ 32'(a)};
    endfunction

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] hi;
        logic [31:0] lo;
        int          exp_cnt;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 req", 64'(d_req_valid), 64'd0);
        host_rd(A_STS, v); check("R1 status", 64'(v), 64'd0);
        host_rd(A_HI, v);  check("R1 data0", 64'(v), 64'd0);
        host_rd(A_LO, v);  check("R1 data1", 64'(v), 64'd0);
        host_rd(A_CMD, v); check("R1 cmd", 64'(v), 64'd0);

        // R2 / R3 sweep over every downstream register with varied latencies
        exp_cnt = 0;
        for (int a = 0; a < NUM_REGS; a++) begin
            acc_dly = a % 3;
            rsp_dly = (a / 3) % 4;
            host_wr(A_HI, pat(a)[63:32]);
            host_wr(A_LO, pat(a)[31:0]);
            host_wr(A_CMD, 32'h8000_0000 | 32'(a));
            wait_idle();
            exp_cnt++;
            @(posedge clk); #1;
            check("R2 write data", mem[a], pat(a));
            check("R2 one request", 64'(ds_req_count), 64'(exp_cnt));
        end
        for (int a = 0; a < NUM_REGS; a++) begin
            acc_dly = (a + 1) % 3;
            rsp_dly = a % 4;
            host_wr(A_HI, 32'h0);
            host_wr(A_LO, 32'h0);
            host_wr(A_CMD, 32'(a));
            wait_idle();
            host_rd(A_HI, hi);
            host_rd(A_LO, lo);
            check("R3 read halves", {hi, lo}, pat(a));
        end
        host_rd(A_STS, v); check("R3 no error", 64'(v), 64'd0);
        host_rd(A_CMD, v); check("R3 cmd readback", 64'(v), 64'(NUM_REGS - 1));

        // R4 busy window
        acc_dly = 4; rsp_dly = 2;
        host_wr(A_CMD, 32'd1);
        host_rd(A_STS, v); check("R4 busy set", 64'(v[0]), 64'd1);
        wait_idle();
        host_rd(A_STS, v); check("R4 busy clear", 64'(v[0]), 64'd0);
        acc_dly = 0; rsp_dly = 0;

        // R5 command while busy
        @(posedge clk); #1 rsp_mode = 1;
        exp_cnt = ds_req_count + 1;
        host_wr(A_CMD, 32'd2);
        host_wr(A_CMD, 32'h8000_0007);
        host_rd(A_CMD, v); check("R5 cmd unchanged", 64'(v), 64'd2);
        @(posedge clk); #1 rsp_mode = 0;
        wait_idle();
        @(posedge clk); #1;
        check("R5 single request", 64'(ds_req_count), 64'(exp_cnt));
        check("R5 no write", mem[7], pat(7));
        host_rd(A_STS, v); check("R5 err set", 64'(v), 64'h8000_0000);
        host_wr(A_CLR, 32'h0);
        host_rd(A_STS, v); check("R8 clear", 64'(v), 64'd0);

        // R6 address outside the downstream map
        exp_cnt = ds_req_count;
        host_wr(A_CMD, 32'(NUM_REGS));
        host_rd(A_STS, v); check("R6 err no busy", 64'(v), 64'h8000_0000);
        host_wr(A_CLR, 32'hFFFF_FFFF);
        host_wr(A_CMD, 32'hFFFF_FFFF);
        host_rd(A_STS, v); check("R6 max addr", 64'(v), 64'h8000_0000);
        @(posedge clk); #1;
        check("R6 no request", 64'(ds_req_count), 64'(exp_cnt));
        host_rd(A_CMD, v); check("R6 cmd unchanged", 64'(v), 64'd2);
        host_wr(A_CLR, 32'h5);

        // R7 downstream error response
        host_wr(A_HI, 32'h1111_2222);
        host_wr(A_LO, 32'h3333_4444);
        err_inject = 1'b1;
        host_wr(A_CMD, 32'd4);
        wait_idle();
        host_rd(A_HI, hi);
        host_rd(A_LO, lo);
        check("R7 data kept", {hi, lo}, 64'h1111_2222_3333_4444);
        host_rd(A_STS, v); check("R7 err set", 64'(v), 64'h8000_0000);
        host_wr(A_CMD, 32'h8000_0006);
        wait_idle();
        err_inject = 1'b0;
        check("R7 write dropped", mem[6], pat(6));
        host_wr(A_CLR, 32'h0);

        // R8 clear write lands with an error response: error survives
        @(posedge clk); #1 rsp_mode = 1;
        host_wr(A_CMD, 32'd3);
        repeat (8) @(posedge clk);
        coincide(A_CLR, 32'h0, 1'b1, 64'h0);
        host_rd(A_STS, v); check("R8 set wins", 64'(v), 64'h8000_0000);
        host_wr(A_CLR, 32'h0);
        host_rd(A_STS, v); check("R8 clear after", 64'(v), 64'd0);

        // R8 clear write lands with a good response: cleared, data loaded
        host_wr(A_CMD, 32'h4000_0000);
        @(posedge clk); #1 rsp_mode = 1;
        host_wr(A_CMD, 32'd8);
        repeat (8) @(posedge clk);
        coincide(A_CLR, 32'h0, 1'b0, 64'hCAFE_F00D_0BAD_BEEF);
        host_rd(A_STS, v); check("R8 good clear", 64'(v), 64'd0);
        host_rd(A_HI, hi);
        host_rd(A_LO, lo);
        check("R3 manual load", {hi, lo}, 64'hCAFE_F00D_0BAD_BEEF);

        // R9 host data write in the same cycle as a read completion
        @(posedge clk); #1 rsp_mode = 1;
        host_wr(A_CMD, 32'd5);
        repeat (8) @(posedge clk);
        coincide(A_HI, 32'h1234_5678, 1'b0, 64'h0123_4567_89AB_CDEF);
        host_rd(A_HI, hi);
        host_rd(A_LO, lo);
        check("R9 completion wins", {hi, lo}, 64'h0123_4567_89AB_CDEF);
        host_wr(A_LO, 32'h0F0F_0F0F);
        host_rd(A_LO, v); check("R9 host write", 64'(v), 64'h0F0F_0F0F);

        // R10 data snapshot at command acceptance
        acc_dly = 10;
        host_wr(A_HI, 32'hAAAA_0001);
        host_wr(A_LO, 32'hBBBB_0002);
        host_wr(A_CMD, 32'h8000_0009);
        host_wr(A_HI, 32'hCCCC_0003);
        host_wr(A_LO, 32'hDDDD_0004);
        wait_idle();
        acc_dly = 0;
        @(posedge clk); #1;
        check("R10 snapshot", mem[9], 64'hAAAA_0001_BBBB_0002);
        host_rd(A_HI, v); check("R9 readback", 64'(v), 64'hCCCC_0003);

        // R11 unmapped offsets and response timing
        host_rd(8'h0C, v); check("R11 unmapped 0C", 64'(v), 64'd0);
        check("R11 rvalid", 64'(last_rv), 64'd1);
        host_rd(8'h14, v); check("R11 unmapped 14", 64'(v), 64'd0);
        host_wr(8'h10, 32'hFFFF_FFFF);
        host_wr(8'h1F, 32'hFFFF_FFFF);
        host_rd(A_HI, v);  check("R11 data0 kept", 64'(v), 64'hCCCC_0003);
        host_rd(A_LO, v);  check("R11 data1 kept", 64'(v), 64'hDDDD_0004);
        host_rd(A_STS, v); check("R11 status kept", 64'(v), 64'd0);
        @(negedge clk);
        check("R11 no stray rvalid", 64'(h_rvalid), 64'd0);

        finish_run();
    end

endmodule